// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a simple request/acknowledge host port and an external 32K x 8 asynchronous static RAM. The RAM has active-low chip select, write strobe and output enable pins and one shared data bus. The host presents a 15-bit word address, an 8-bit write byte and a direction flag. The controller registers the request when it accepts it. It then drives the strobes, the address and the data-bus driver in a fixed order of phases, and ends each access with a one-cycle done pulse. A read returns its byte together with that pulse.

Every analogue timing limit of the RAM is met by counting system clocks. Each phase length is a parameter whose default is the smallest whole number of clock periods that covers the nanosecond limit. Writes are strobe-controlled: the RAM latches the byte when the write strobe returns high, and the driver stays on through that edge. A write that follows a read waits extra standby cycles so that the RAM outputs can float before the controller drives the bus. The data pad is split into an output value, an output enable and an input value, so that the tri-state buffer can live in the pad ring.

Top module: `sramc_top`

## Requirements
- R1: While reset is low and in the first cycle after it: ramCeN, ramWeN and ramOeN are 1, ramDqOe is 0, doneValid is 0 and reqReady is 1.
- R2: When idle, all three strobes are high. During a write, ramCeN=0, ramWeN=0 and ramOeN=1. During a read, ramCeN=0, ramOeN=0 and ramWeN=1. ramWeN is never low while ramCeN is high.
- R3: A request is accepted at the clock edge where reqValid and reqReady are both 1. In the first cycle after that edge (its address cycle), ramAddr carries the accepted address while ramCeN is still 1. ramAddr stays unchanged for as long as ramCeN remains 0.
- R4: A write holds ramWeN low for FLOAT+DRIVE consecutive cycles. FLOAT is ceil(tWZ/T) and DRIVE is max(ceil(tDW/T), ceil(tWP/T)-FLOAT), where T is the clock period. The driver is off in the first FLOAT of those cycles and on in the last DRIVE. It stays on in the cycle where ramWeN is back high and ramCeN is still low. With an 8 ns clock, FLOAT=1 and DRIVE=1.
- R5: Counting the acceptance edge as edge 1, doneValid rises at edge 2+FLOAT+DRIVE for a write (edge 4 by default), plus the turnaround of R7 where it applies. The addressed RAM byte then holds the write byte.
- R6: A read holds ramOeN low for READ_WAIT=ceil(tAA/T) cycles (2 by default) and samples ramDqIn at the edge that ends the last of them. At edge 2+READ_WAIT, doneValid rises with that byte on rdData, and ramCeN and ramOeN are back high.
- R7: A write accepted when the previous access was a read gets TURN=ceil(tOHZ/T) standby cycles (1 by default) before its address cycle. ramDqOe is never 1 in a cycle where ramOeN is 0, nor in the cycle right after ramOeN rises.
- R8: reqReady is 1 only while idle. A request held on the port while reqReady is 0 is ignored: it causes no write and no extra done. Each accepted request gives exactly one single-cycle done pulse.
- R9: The data bus is never driven at the same time by the controller and by a RAM that drives unknown data in the first cycle of a read and keeps driving for one cycle after ramOeN rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Host request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 15 | Word address |
| reqWdata | input | 8 | Byte to write |
| reqReady | output | 1 | Controller idle, request will be taken |
| doneValid | output | 1 | One-cycle completion pulse |
| rdData | output | 8 | Read byte, valid with doneValid after a read |
| ramAddr | output | 15 | RAM address pins |
| ramCeN | output | 1 | RAM chip select, active low |
| ramWeN | output | 1 | RAM write strobe, active low |
| ramOeN | output | 1 | RAM output enable, active low |
| ramDqOut | output | 8 | Value for the data pad driver |
| ramDqOe | output | 1 | Data pad driver enable |
| ramDqIn | input | 8 | Value seen on the data pads |

## Verification
The bench builds the controller with its defaults: an 8 ns clock and the fastest timing limits, which give one float cycle, one drive cycle, a two-cycle read wait and one turnaround cycle. At these smallest counts, removing or adding a single cycle in any phase shows up in the measured latencies. The RAM model is tight: it returns unknown data in the first read cycle and floats one cycle after output enable rises, so any early capture or early driving is visible. Addresses are mostly drawn from a 64-word window, which makes read-after-write hits, read-then-write turnarounds and writes back-to-back with writes frequent.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TURN,
    ST_SETUP,
    ST_WR_FLOAT,
    ST_WR_DRIVE,
    ST_WR_END,
    ST_RD_WAIT,
    ST_RD_DONE
  } ctrlState_e;

  // Strobes from control to datapath: pad controls are registered,
  // load and capture are single-cycle enables for the datapath flops.
  typedef struct packed {
    logic ceN;
    logic weN;
    logic oeN;
    logic drive;
    logic done;
    logic load;
    logic capture;
  } strobes_t;

  // Smallest clock count covering a limit given in picoseconds, never below 1.
  function automatic int ceilCycles(input int limitPs, input int periodPs);
    int n;
    n = (limitPs + periodPs - 1) / periodPs;
    return (n < 1) ? 1 : n;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sramc_ctrl.sv
module sramc_ctrl
  import sramc_pkg::*;
#(
  parameter int FLOAT_CYC     = 1,
  parameter int DRIVE_CYC     = 1,
  parameter int READ_WAIT_CYC = 2,
  parameter int TURN_CYC      = 1
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     reqWrite,
  output logic     reqReady,
  output strobes_t strobes
);

  localparam int MAX_CYC = maxOf(maxOf(FLOAT_CYC, DRIVE_CYC), maxOf(READ_WAIT_CYC, TURN_CYC));
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  ctrlState_e stateQ, stateD;
  logic [CNT_W-1:0] cntQ, cntD;
  logic wrQ, wrD;
  logic lastRdQ, lastRdD;
  strobes_t padQ;
  logic lastCnt;

  assign lastCnt = (cntQ == CNT_W'(1));

  function automatic strobes_t padFor(input ctrlState_e st);
    strobes_t s;
    s = '{ceN: 1'b1, weN: 1'b1, oeN: 1'b1, drive: 1'b0, done: 1'b0, load: 1'b0, capture: 1'b0};
    case (st)
      ST_WR_FLOAT: begin s.ceN = 1'b0; s.weN = 1'b0; end
      ST_WR_DRIVE: begin s.ceN = 1'b0; s.weN = 1'b0; s.drive = 1'b1; end
      ST_WR_END:   begin s.ceN = 1'b0; s.drive = 1'b1; s.done = 1'b1; end
      ST_RD_WAIT:  begin s.ceN = 1'b0; s.oeN = 1'b0; end
      ST_RD_DONE:  begin s.done = 1'b1; end
      default:     ;
    endcase
    return s;
  endfunction

  always_comb begin
    stateD  = stateQ;
    cntD    = cntQ;
    wrD     = wrQ;
    lastRdD = lastRdQ;
    case (stateQ)
      ST_IDLE: begin
        if (reqValid) begin
          wrD = reqWrite;
          if (reqWrite) lastRdD = 1'b0;
          if (reqWrite && lastRdQ) begin
            stateD = ST_TURN;
            cntD   = CNT_W'(TURN_CYC);
          end else begin
            stateD = ST_SETUP;
          end
        end
      end
      ST_TURN: begin
        if (lastCnt) stateD = ST_SETUP;
        else cntD = cntQ - 1'b1;
      end
      ST_SETUP: begin
        if (wrQ) begin
          stateD = ST_WR_FLOAT;
          cntD   = CNT_W'(FLOAT_CYC);
        end else begin
          stateD = ST_RD_WAIT;
          cntD   = CNT_W'(READ_WAIT_CYC);
        end
      end
      ST_WR_FLOAT: begin
        if (lastCnt) begin
          stateD = ST_WR_DRIVE;
          cntD   = CNT_W'(DRIVE_CYC);
        end else begin
          cntD = cntQ - 1'b1;
        end
      end
      ST_WR_DRIVE: begin
        if (lastCnt) stateD = ST_WR_END;
        else cntD = cntQ - 1'b1;
      end
      ST_WR_END: stateD = ST_IDLE;
      ST_RD_WAIT: begin
        if (lastCnt) begin
          stateD  = ST_RD_DONE;
          lastRdD = 1'b1;
        end else begin
          cntD = cntQ - 1'b1;
        end
      end
      ST_RD_DONE: stateD = ST_IDLE;
      default:    stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      cntQ    <= '0;
      wrQ     <= 1'b0;
      lastRdQ <= 1'b0;
      padQ    <= padFor(ST_IDLE);
    end else begin
      stateQ  <= stateD;
      cntQ    <= cntD;
      wrQ     <= wrD;
      lastRdQ <= lastRdD;
      padQ    <= padFor(stateD);
    end
  end

  assign reqReady = (stateQ == ST_IDLE);

  always_comb begin
    strobes         = padQ;
    strobes.load    = (stateQ == ST_IDLE) && reqValid;
    strobes.capture = (stateQ == ST_RD_WAIT) && lastCnt;
  end

endmodule

// File: rtl/sramc_dp.sv
module sramc_dp
  import sramc_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strobes,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] ramDqIn,
  output logic [ADDR_W-1:0] ramAddr,
  output logic              ramCeN,
  output logic              ramWeN,
  output logic              ramOeN,
  output logic [DATA_W-1:0] ramDqOut,
  output logic              ramDqOe,
  output logic [DATA_W-1:0] rdData,
  output logic              doneValid
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdataQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      rdataQ <= '0;
    end else begin
      if (strobes.load) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
      end
      if (strobes.capture) rdataQ <= ramDqIn;
    end
  end

  assign ramAddr   = addrQ;
  assign ramDqOut  = wdataQ;
  assign ramDqOe   = strobes.drive;
  assign ramCeN    = strobes.ceN;
  assign ramWeN    = strobes.weN;
  assign ramOeN    = strobes.oeN;
  assign rdData    = rdataQ;
  assign doneValid = strobes.done;

endmodule

// File: rtl/sramc_top.sv
module sramc_top
  import sramc_pkg::*;
#(
  parameter int ADDR_W        = 15,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_PS = 8000,
  parameter int T_WP_PS       = 7000,
  parameter int T_DW_PS       = 5000,
  parameter int T_ACC_PS      = 10000,
  parameter int T_OHZ_PS      = 3000,
  parameter int T_WZ_PS       = 5000,
  parameter int WE_LOW_CYC    = ceilCycles(T_WP_PS, CLK_PERIOD_PS),
  parameter int DSETUP_CYC    = ceilCycles(T_DW_PS, CLK_PERIOD_PS),
  parameter int READ_WAIT_CYC = ceilCycles(T_ACC_PS, CLK_PERIOD_PS),
  parameter int TURN_CYC      = ceilCycles(T_OHZ_PS, CLK_PERIOD_PS),
  parameter int FLOAT_CYC     = ceilCycles(T_WZ_PS, CLK_PERIOD_PS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              reqReady,
  output logic              doneValid,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] ramAddr,
  output logic              ramCeN,
  output logic              ramWeN,
  output logic              ramOeN,
  output logic [DATA_W-1:0] ramDqOut,
  output logic              ramDqOe,
  input  logic [DATA_W-1:0] ramDqIn
);

  // Driven part of the strobe-low time covers both data setup and the
  // remainder of the minimum strobe width.
  localparam int DRIVE_CYC = maxOf(DSETUP_CYC, WE_LOW_CYC - FLOAT_CYC);

  strobes_t strobes;

  sramc_ctrl #(
    .FLOAT_CYC    (FLOAT_CYC),
    .DRIVE_CYC    (DRIVE_CYC),
    .READ_WAIT_CYC(READ_WAIT_CYC),
    .TURN_CYC     (TURN_CYC)
  ) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqReady(reqReady),
    .strobes (strobes)
  );

  sramc_dp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .ramDqIn  (ramDqIn),
    .ramAddr  (ramAddr),
    .ramCeN   (ramCeN),
    .ramWeN   (ramWeN),
    .ramOeN   (ramOeN),
    .ramDqOut (ramDqOut),
    .ramDqOe  (ramDqOe),
    .rdData   (rdData),
    .doneValid(doneValid)
  );

endmodule

// File: rtl/sramc_chk.sv
module sramc_chk #(
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              doneValid,
  input logic [ADDR_W-1:0] ramAddr,
  input logic              ramCeN,
  input logic              ramWeN,
  input logic              ramOeN,
  input logic              ramDqOe
);

  // R2
  write_needs_select_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ramWeN |-> !ramCeN);

  // R2
  write_keeps_oe_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ramWeN |-> ramOeN);

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ramCeN && !$past(ramCeN)) |-> $stable(ramAddr));

  // R4
  drive_at_we_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ramWeN) |-> ramDqOe);

  // R7
  no_drive_oe_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    ramDqOe |-> ramOeN);

  // R7
  no_drive_after_oe_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ramOeN) |-> !ramDqOe);

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

  // R8
  ready_only_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (ramCeN && ramWeN && ramOeN && !ramDqOe));

endmodule

bind sramc_top sramc_chk #(.ADDR_W(ADDR_W)) i_sramc_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqReady (reqReady),
  .doneValid(doneValid),
  .ramAddr  (ramAddr),
  .ramCeN   (ramCeN),
  .ramWeN   (ramWeN),
  .ramOeN   (ramOeN),
  .ramDqOe  (ramDqOe)
);

// File: tb/test_sramc_top.sv
`timescale 1ns/1ps
module test_sramc_top;

  // Bench-side phase counts from the nanosecond limits at an 8 ns clock.
  localparam int PER   = 8000;
  localparam int FLOAT = (5000 + PER - 1) / PER;
  localparam int WPC   = (7000 + PER - 1) / PER;
  localparam int DSC   = (5000 + PER - 1) / PER;
  localparam int DRIVE = (DSC > WPC - FLOAT) ? DSC : (WPC - FLOAT);
  localparam int RWAIT = (10000 + PER - 1) / PER;
  localparam int TURN  = (3000 + PER - 1) / PER;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [14:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic reqReady, doneValid;
  logic [7:0] rdData, ramDqOut, ramDqIn;
  logic [14:0] ramAddr;
  logic ramCeN, ramWeN, ramOeN, ramDqOe;

  always #4 clk = ~clk;

  sramc_top i_sramc_top (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqReady(reqReady),
    .doneValid(doneValid), .rdData(rdData), .ramAddr(ramAddr),
    .ramCeN(ramCeN), .ramWeN(ramWeN), .ramOeN(ramOeN),
    .ramDqOut(ramDqOut), .ramDqOe(ramDqOe), .ramDqIn(ramDqIn)
  );

  int total = 0, bad = 0;
  int contention = 0, dones = 0, accepted = 0;
  bit finished = 1'b0;
  bit benchLastRead = 1'b0;
  logic [7:0] expMem [int];

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic logic [7:0] expByte(input logic [14:0] a);
    return expMem.exists(int'(a)) ? expMem[int'(a)] : 8'h00;
  endfunction

  // ---------------- RAM model and bus monitors ----------------
  logic [7:0] modelMem [int];
  bit   mDrive = 1'b0;
  logic [7:0] mVal = 8'h00;
  int   rdRun = 0, weLowRun = 0, drvRun = 0;
  logic prevWeN = 1'b1, prevOeN = 1'b1;

  assign ramDqIn = mDrive ? mVal : (ramDqOe ? ramDqOut : 8'h00);

  always @(negedge clk) begin
    if (!rstN) begin
      mDrive = 1'b0; rdRun = 0; weLowRun = 0; drvRun = 0;
      prevWeN = 1'b1; prevOeN = 1'b1;
    end else begin
      if (ramDqOe && mDrive) contention++;
      // read window: unknown first cycle, data after, one linger cycle
      if (!ramCeN && !ramOeN && ramWeN) begin
        rdRun++;
        mDrive = 1'b1;
        mVal = (rdRun >= 2) ? (modelMem.exists(int'(ramAddr)) ? modelMem[int'(ramAddr)] : 8'h00) : 8'hxx;
      end else if (rdRun > 0) begin
        rdRun = 0; mDrive = 1'b1; mVal = 8'hxx;
      end else begin
        mDrive = 1'b0;
      end
      if (ramDqOe && mDrive) contention++;
      // R7: driver never on with OE low now or in the previous cycle
      if (ramDqOe)
        chk(ramOeN && prevOeN, "R7 driver on near OE low", {ramOeN, prevOeN}, 2'b11);
      // R4: write strobe shape, capture on strobe rise
      if (!ramWeN) begin
        weLowRun++;
        if (ramDqOe) drvRun++;
      end else if (!prevWeN) begin
        chk(weLowRun == FLOAT + DRIVE, "R4 WE low width", weLowRun, FLOAT + DRIVE);
        chk(drvRun == DRIVE, "R4 driven cycles before WE rise", drvRun, DRIVE);
        chk(ramDqOe && !ramCeN, "R4 data held at WE rise", {ramDqOe, ramCeN}, 2'b10);
        if (!ramCeN) modelMem[int'(ramAddr)] = ramDqOe ? ramDqOut : 8'hxx;
        weLowRun = 0; drvRun = 0;
      end
      if (doneValid) dones++;
      prevWeN = ramWeN;
      prevOeN = ramOeN;
    end
  end

  // ---------------- host driver ----------------
  task automatic hostAccess(input bit wr, input logic [14:0] a, input logic [7:0] d, input bit holdJunk);
    int lat;
    int turn;
    int expLat;
    turn = (wr && benchLastRead) ? TURN : 0;
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    accepted++;
    lat = 1;
    if (holdJunk) begin
      reqWrite = 1'b1; reqAddr = 15'h7FFF; reqWdata = 8'h5A;
    end else begin
      reqValid = 1'b0;
    end
    forever begin
      if (lat == 1 + turn)
        chk(ramAddr == a && ramCeN, "R3 address cycle", {ramCeN, ramAddr}, {1'b1, a});
      if (lat == 2 + turn) begin
        if (wr) chk({ramCeN, ramWeN, ramOeN} == 3'b001, "R2 write encoding", {ramCeN, ramWeN, ramOeN}, 3'b001);
        else    chk({ramCeN, ramWeN, ramOeN} == 3'b010, "R2 read encoding", {ramCeN, ramWeN, ramOeN}, 3'b010);
      end
      if (doneValid || lat > 60) break;
      @(negedge clk);
      lat++;
    end
    reqValid = 1'b0;
    if (wr) begin
      expLat = 2 + FLOAT + DRIVE + turn;
      chk(lat == expLat, turn != 0 ? "R7 write latency after read" : "R5 write latency", lat, expLat);
      expMem[int'(a)] = d;
    end else begin
      expLat = 2 + RWAIT;
      chk(lat == expLat, "R6 read latency", lat, expLat);
      chk(rdData == expByte(a), "R6 read data", rdData, expByte(a));
      chk(ramCeN && ramOeN, "R6 strobes high at done", {ramCeN, ramOeN}, 2'b11);
    end
    benchLastRead = !wr;
  endtask

  // ---------------- main sequence ----------------
  initial begin
    void'($urandom(32'd7351));
    repeat (3) @(negedge clk);
    chk({ramCeN, ramWeN, ramOeN, ramDqOe, doneValid, reqReady} == 6'b111001,
        "R1 reset outputs", {ramCeN, ramWeN, ramOeN, ramDqOe, doneValid, reqReady}, 6'b111001);
    @(posedge clk); rstN = 1'b1;
    @(negedge clk);
    chk({ramCeN, ramWeN, ramOeN, ramDqOe, doneValid, reqReady} == 6'b111001,
        "R1 first cycle after reset", {ramCeN, ramWeN, ramOeN, ramDqOe, doneValid, reqReady}, 6'b111001);

    // directed corners
    hostAccess(1'b1, 15'h7FFF, 8'hC3, 1'b0);   // R5 write from idle
    hostAccess(1'b1, 15'h0000, 8'hA5, 1'b0);   // R5 write after write, no turnaround
    hostAccess(1'b0, 15'h7FFF, 8'h00, 1'b0);   // R6 read back
    hostAccess(1'b0, 15'h0000, 8'h00, 1'b0);   // R6 read after read
    hostAccess(1'b1, 15'h0001, 8'hFF, 1'b0);   // R7 write after read
    hostAccess(1'b1, 15'h0010, 8'h3C, 1'b1);   // R8 junk request held while busy
    hostAccess(1'b0, 15'h0001, 8'h00, 1'b1);   // R8 junk held during a read
    hostAccess(1'b0, 15'h7FFF, 8'h00, 1'b0);   // R8 junk write must not have landed
    hostAccess(1'b0, 15'h0010, 8'h00, 1'b0);
    hostAccess(1'b0, 15'h4321, 8'h00, 1'b0);   // never written: reads zero

    // constrained random
    for (int i = 0; i < 300; i++) begin
      logic [14:0] a;
      a = ($urandom_range(0, 7) == 0) ? 15'($urandom) : 15'($urandom_range(0, 63));
      if (a == 15'h7FFF) a = 15'h7FFE;
      hostAccess($urandom_range(0, 1) == 1, a, 8'($urandom), $urandom_range(0, 5) == 0);
    end
    hostAccess(1'b0, 15'h7FFF, 8'h00, 1'b0);   // R8 still the directed value

    repeat (3) @(negedge clk);
    chk(contention == 0, "R9 bus contention cycles", contention, 0);
    chk(dones == accepted, "R8 done pulses per accepted request", dones, accepted);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule